// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

This block is a timer-counter. It either counts clock cycles or decodes a two-phase quadrature encoder pair (phase A and phase B) into an up/down position count. The count is bounded by a programmable ceiling and wraps at both ends. The phase inputs must already be synchronised to `clk_i`. The block samples them once per clock and finds edges by comparing each phase with its value from the previous cycle.

Software drives the block through a small single-cycle register port with five registers:

| Address | Register | Fields |
|---|---|---|
| 0 | control | bit0 enable, bit1 ceiling preload, bit4 direction (read-only) |
| 1 | mode select | 3-bit mode |
| 2 | count | read/write |
| 3 | ceiling | reads back the active ceiling |
| 4 | event | bit0 forces an update; always reads 0 |

Reads are combinational from `addr_i`. A write is taken on the rising clock edge while `we_i` is high.

Top module: `qenc_timer`

## Requirements
- R1: After reset the count is 0, the active ceiling is all ones, enable, preload and direction are 0, and the mode is 0.
- R2: While enable (control bit0) is 0, phase edges and clock cycles leave the count unchanged.
- R3: In mode 0 with enable set, the count rises by one every clock and the direction bit reads 0.
- R4: In mode 1, only a change of A with B unchanged is a step. A rising A with B low, or a falling A with B high, counts up. The other two cases count down.
- R5: In mode 2, only a change of B with A unchanged is a step. A rising B with A high, or a falling B with A low, counts up. The other two cases count down.
- R6: In mode 3, single-phase changes of either A or B are steps, using the R4 and R5 rules. One full forward encoder cycle adds four, and one full reverse cycle subtracts four.
- R7: A cycle in which A and B both change is invalid: the count and the direction bit stay as they were.
- R8: Stepping up from a count at or above the ceiling gives 0. Stepping down from 0 gives the ceiling.
- R9: With preload (control bit1) clear, a ceiling write becomes the active ceiling on the next cycle.
- R10: With preload set, a ceiling write leaves the active ceiling unchanged until bit0 of the event register is written as 1. That update loads the pending value, and the event register always reads 0.
- R11: A count write loads the written value on the next cycle and wins over any step in the same cycle.
- R12: Control bit4 is 0 after an up step and 1 after a down step. It holds between steps.
- R13: Mode values 4 to 7 produce no steps and the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Encoder phase A, synchronised |
| b_i | input | 1 | Encoder phase B, synchronised |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | CNT_W | Register write data |
| rdata_o | output | CNT_W | Register read data for addr_i |

## Verification
The assertions take for granted that A and B change only on clock edges and are already synchronised. They also assume that at most one register access happens per cycle, so an update event never coincides with a ceiling write. The stimulus meets both conditions: it drives every input on the falling clock edge and issues one register write at a time. The random phase walk is mostly single-phase changes, with occasional simultaneous changes of both phases to exercise the invalid-sample rule. Count writes and mode changes are interleaved with the walk.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] REG_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] REG_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] REG_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] REG_CEIL  = 3'd3;
  localparam logic [ADDR_W-1:0] REG_EVENT = 3'd4;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_PRE = 1;
  localparam int CTRL_DIR = 4;

  localparam logic [2:0] MODE_CLK = 3'd0;
  localparam logic [2:0] MODE_XA  = 3'd1;
  localparam logic [2:0] MODE_XB  = 3'd2;
  localparam logic [2:0] MODE_X4  = 3'd3;
endpackage

// File: rtl/qenc_decode.sv
module qenc_decode
  import qenc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_i,
  input  logic       b_i,
  input  logic [2:0] mode_i,
  output logic       a_prev_o,
  output logic       b_prev_o,
  output logic       step_o,
  output logic       up_o
);
  logic a_q, b_q;
  logic a_chg, b_chg, solo_a, solo_b, up_a, up_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_chg  = a_i ^ a_q;
  assign b_chg  = b_i ^ b_q;
  assign solo_a = a_chg & ~b_chg;
  assign solo_b = b_chg & ~a_chg;
  // forward quadrature: 00 -> 10 -> 11 -> 01 -> 00
  assign up_a   = a_i ^ b_i;
  assign up_b   = ~(a_i ^ b_i);

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (mode_i)
      MODE_CLK: begin
        step_o = 1'b1;
        up_o   = 1'b1;
      end
      MODE_XA: begin
        step_o = solo_a;
        up_o   = up_a;
      end
      MODE_XB: begin
        step_o = solo_b;
        up_o   = up_b;
      end
      MODE_X4: begin
        step_o = solo_a | solo_b;
        up_o   = solo_a ? up_a : up_b;
      end
      default: begin
        step_o = 1'b0;
        up_o   = 1'b1;
      end
    endcase
  end

  assign a_prev_o = a_q;
  assign b_prev_o = b_q;
endmodule

// File: rtl/qenc_ceiling.sv
module qenc_ceiling #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             update_i,
  output logic [CNT_W-1:0] ceil_o
);
  logic [CNT_W-1:0] pend_q, ceil_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '1;
      ceil_q <= '1;
    end else begin
      if (wr_i) begin
        pend_q <= wdata_i;
        if (!preload_i) ceil_q <= wdata_i;
      end else if (update_i) begin
        ceil_q <= pend_q;
      end
    end
  end

  assign ceil_o = ceil_q;
endmodule

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] ceil_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, cnt_dec;
  logic             dir_q, adv;

  assign adv     = en_i & step_i;
  assign cnt_inc = (cnt_q >= ceil_i) ? '0 : cnt_q + 1'b1;
  assign cnt_dec = (cnt_q == '0) ? ceil_i : cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      if (wr_i)     cnt_q <= wdata_i;
      else if (adv) cnt_q <= up_i ? cnt_inc : cnt_dec;
      if (adv) dir_q <= ~up_i;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [2:0]       addr_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o
);
  logic             en_q, pre_q;
  logic [2:0]       mode_q;
  logic             step, up, a_prev, b_prev, dir;
  logic [CNT_W-1:0] cnt_q, ceil_q;
  logic             wr_ctrl, wr_mode, wr_cnt, wr_ceil, upd;

  assign wr_ctrl = we_i && (addr_i == REG_CTRL);
  assign wr_mode = we_i && (addr_i == REG_MODE);
  assign wr_cnt  = we_i && (addr_i == REG_COUNT);
  assign wr_ceil = we_i && (addr_i == REG_CEIL);
  assign upd     = we_i && (addr_i == REG_EVENT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      pre_q  <= 1'b0;
      mode_q <= MODE_CLK;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[CTRL_EN];
        pre_q <= wdata_i[CTRL_PRE];
      end
      if (wr_mode) mode_q <= wdata_i[2:0];
    end
  end

  qenc_decode i_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .a_i      (a_i),
    .b_i      (b_i),
    .mode_i   (mode_q),
    .a_prev_o (a_prev),
    .b_prev_o (b_prev),
    .step_o   (step),
    .up_o     (up)
  );

  qenc_ceiling #(.CNT_W(CNT_W)) i_ceiling (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .preload_i (pre_q),
    .wr_i      (wr_ceil),
    .wdata_i   (wdata_i),
    .update_i  (upd),
    .ceil_o    (ceil_q)
  );

  qenc_counter #(.CNT_W(CNT_W)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_q),
    .step_i  (step),
    .up_i    (up),
    .ceil_i  (ceil_q),
    .wr_i    (wr_cnt),
    .wdata_i (wdata_i),
    .cnt_o   (cnt_q),
    .dir_o   (dir)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_EN]  = en_q;
        rdata_o[CTRL_PRE] = pre_q;
        rdata_o[CTRL_DIR] = dir;
      end
      REG_MODE:  rdata_o[2:0] = mode_q;
      REG_COUNT: rdata_o = cnt_q;
      REG_CEIL:  rdata_o = ceil_q;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/qenc_timer_chk.sv
module qenc_timer_chk
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             a_i,
  input logic             b_i,
  input logic [2:0]       addr_i,
  input logic             we_i,
  input logic [CNT_W-1:0] wdata_i,
  input logic             en,
  input logic             pre,
  input logic [2:0]       mode,
  input logic             step,
  input logic             up,
  input logic             a_prev,
  input logic             b_prev,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ceil
);
  logic cnt_wr;
  assign cnt_wr = we_i && (addr_i == REG_COUNT);

  // R2
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_wr) |=> $stable(cnt));

  // R3
  clk_mode_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && mode == MODE_CLK && !cnt_wr && cnt < ceil) |=> cnt == $past(cnt) + 1'b1);

  // R7
  double_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_i != a_prev) && (b_i != b_prev) && mode != MODE_CLK) |-> !step);

  // R8
  wrap_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && step && up && !cnt_wr && cnt >= ceil) |=> cnt == '0);

  // R8
  wrap_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && step && !up && !cnt_wr && cnt == '0) |=> cnt == $past(ceil));

  // R10
  preload_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre && we_i && addr_i == REG_CEIL) |=> $stable(ceil));

  // R11
  cnt_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr |=> cnt == $past(wdata_i));

  // R13
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode > MODE_X4) |-> !step);
endmodule

bind qenc_timer qenc_timer_chk #(.CNT_W(CNT_W)) i_qenc_timer_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .a_i     (a_i),
  .b_i     (b_i),
  .addr_i  (addr_i),
  .we_i    (we_i),
  .wdata_i (wdata_i),
  .en      (en_q),
  .pre     (pre_q),
  .mode    (mode_q),
  .step    (step),
  .up      (up),
  .a_prev  (a_prev),
  .b_prev  (b_prev),
  .cnt     (cnt_q),
  .ceil    (ceil_q)
);

// File: tb/test_qenc_timer.sv
module test_qenc_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a = 1'b0, b = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [W-1:0] m_cnt = '0, m_ceil = '1, m_pend = '1;
  logic         m_en = 0, m_pre = 0, m_dir = 0, m_pa = 0, m_pb = 0;
  logic [2:0]   m_mode = 3'd0;

  always #10 clk = ~clk;

  qenc_timer #(.CNT_W(W)) i_qenc_timer (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model(input logic w, input logic [2:0] ad, input logic [W-1:0] d,
                       input logic na, input logic nb);
    logic ae, be, st, u;
    ae = (na != m_pa);
    be = (nb != m_pb);
    st = 0;
    u = 1;
    case (m_mode)
      3'd0: st = 1;
      3'd1: begin st = ae && !be; u = na ^ nb; end
      3'd2: begin st = be && !ae; u = !(na ^ nb); end
      3'd3: begin
        if (ae && !be) begin st = 1; u = na ^ nb; end
        else if (be && !ae) begin st = 1; u = !(na ^ nb); end
      end
      default: st = 0;
    endcase
    if (w && ad == 3'd2) m_cnt = d;
    else if (m_en && st) begin
      if (u) m_cnt = (m_cnt >= m_ceil) ? '0 : m_cnt + 1'b1;
      else   m_cnt = (m_cnt == '0) ? m_ceil : m_cnt - 1'b1;
    end
    if (m_en && st) m_dir = !u;
    if (w) begin
      case (ad)
        3'd0: begin m_en = d[0]; m_pre = d[1]; end
        3'd1: m_mode = d[2:0];
        3'd3: begin m_pend = d; if (!m_pre) m_ceil = d; end
        3'd4: if (d[0]) m_ceil = m_pend;
        default: ;
      endcase
    end
    m_pa = na;
    m_pb = nb;
  endtask

  task automatic cyc(input logic w, input logic [2:0] ad, input logic [W-1:0] d,
                     input logic na, input logic nb);
    @(negedge clk);
    we = w; addr = ad; wdata = d; a = na; b = nb;
    @(posedge clk);
    model(w, ad, d, na, nb);
    #1;
    we = 1'b0;
  endtask

  task automatic wr(input logic [2:0] ad, input logic [W-1:0] d);
    cyc(1'b1, ad, d, a, b);
  endtask

  task automatic mv(input logic na, input logic nb);
    cyc(1'b0, 3'd2, '0, na, nb);
  endtask

  task automatic rd(input logic [2:0] ad, output logic [W-1:0] d);
    addr = ad;
    #1;
    d = rdata;
  endtask

  task automatic chk_cnt(input string tag);
    logic [W-1:0] v;
    rd(3'd2, v);
    check(tag, v, m_cnt);
  endtask

  task automatic chk_dir(input string tag);
    logic [W-1:0] v;
    rd(3'd0, v);
    check(tag, {15'd0, v[4]}, {15'd0, m_dir});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state
    rd(3'd0, v); check("R1 ctrl", v, '0);
    rd(3'd1, v); check("R1 mode", v, '0);
    rd(3'd2, v); check("R1 count", v, '0);
    rd(3'd3, v); check("R1 ceiling", v, 16'hffff);

    // R2 disabled, mode 0, edges present
    mv(1, 0); mv(1, 1); mv(0, 1);
    rd(3'd2, v); check("R2 hold while off", v, 16'd0);

    // R3 clock counting
    wr(3'd0, 16'h0001);
    repeat (5) mv(a, b);
    rd(3'd2, v); check("R3 clock count", v, 16'd5);
    chk_dir("R3 dir forward");

    // R9 immediate ceiling, R8 up wrap
    wr(3'd3, 16'd7);
    rd(3'd3, v); check("R9 ceiling now", v, 16'd7);
    repeat (4) mv(a, b);
    chk_cnt("R8 wrap up");
    check("R8 wrap up value", m_cnt, 16'd2);

    // R11 count write wins over clock step
    wr(3'd2, 16'd3);
    rd(3'd2, v); check("R11 count write", v, 16'd3);

    // R4 mode 1
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd1);
    mv(0, 0);
    wr(3'd2, 16'd4);
    wr(3'd0, 16'h0001);
    mv(1, 0); chk_cnt("R4 A rise B low up");    check("R4 val", m_cnt, 16'd5);
    mv(1, 1); chk_cnt("R4 B edge ignored");     check("R4 val", m_cnt, 16'd5);
    mv(0, 1); chk_cnt("R4 A fall B high up");   check("R4 val", m_cnt, 16'd6);
    mv(1, 1); chk_cnt("R4 A rise B high down"); check("R4 val", m_cnt, 16'd5);
    chk_dir("R12 dir after down");
    mv(1, 0); mv(0, 0);
    chk_cnt("R4 A fall B low down");            check("R4 val", m_cnt, 16'd4);

    // R8 down wrap
    wr(3'd2, 16'd0);
    mv(0, 1); mv(1, 1);
    chk_cnt("R8 wrap down");                    check("R8 val", m_cnt, 16'd7);

    // R5 mode 2
    wr(3'd1, 16'd2);
    wr(3'd2, 16'd3);
    mv(1, 0); chk_cnt("R5 B fall A high down"); check("R5 val", m_cnt, 16'd2);
    mv(1, 1); chk_cnt("R5 B rise A high up");   check("R5 val", m_cnt, 16'd3);
    chk_dir("R12 dir after up");
    mv(0, 1); chk_cnt("R5 A edge ignored");     check("R5 val", m_cnt, 16'd3);
    mv(0, 0); chk_cnt("R5 B fall A low up");    check("R5 val", m_cnt, 16'd4);

    // R6 mode 3 full cycles
    wr(3'd1, 16'd3);
    wr(3'd2, 16'd2);
    mv(1, 0); mv(1, 1); mv(0, 1); mv(0, 0);
    chk_cnt("R6 forward cycle");                check("R6 val", m_cnt, 16'd6);
    mv(0, 1); mv(1, 1); mv(1, 0); mv(0, 0);
    chk_cnt("R6 reverse cycle");                check("R6 val", m_cnt, 16'd2);

    // R7 both phases change
    mv(1, 1);
    chk_cnt("R7 invalid sample");               check("R7 val", m_cnt, 16'd2);
    chk_dir("R7 dir held");

    // R2 disabled in mode 3
    wr(3'd0, 16'h0000);
    mv(0, 1); mv(0, 0);
    chk_cnt("R2 hold encoder off");             check("R2 val", m_cnt, 16'd2);

    // R13 undefined mode
    wr(3'd0, 16'h0001);
    wr(3'd1, 16'd5);
    mv(1, 0); mv(1, 1); mv(a, b);
    chk_cnt("R13 mode 5 holds");                check("R13 val", m_cnt, 16'd2);

    // R10 preload
    wr(3'd0, 16'h0003);
    wr(3'd3, 16'd9);
    rd(3'd3, v); check("R10 ceiling deferred", v, 16'd7);
    rd(3'd4, v); check("R10 event reads zero", v, 16'd0);
    wr(3'd4, 16'h0001);
    rd(3'd3, v); check("R10 ceiling after update", v, 16'd9);
    rd(3'd4, v); check("R10 event self clear", v, 16'd0);

    // random phase
    wr(3'd0, 16'h0001);
    wr(3'd3, 16'd150);
    wr(3'd1, 16'd3);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r == 0)      wr(3'd2, 16'($urandom % 150));
      else if (r == 1) wr(3'd1, 16'($urandom % 4));
      else if (r == 2) wr(3'd0, 16'($urandom % 2));
      else begin
        int s;
        s = $urandom % 16;
        if (s < 6)       mv(!a, b);
        else if (s < 12) mv(a, !b);
        else if (s == 12) mv(!a, !b);
        else             mv(a, b);
      end
      chk_cnt("R6 random count");
      if (i % 8 == 0) chk_dir("R12 random dir");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule